// File: doc/BRIEF.md
# Header-Masking Packet Instruction Unit

This unit sits beside a processor's ALU as a custom instruction. On an issued instruction it joins its two 32-bit operands into one 64-bit packet word, with the first operand as the upper (header) half. It then applies a bit operation chosen by an 11-bit command word. The operation either clears or sets a pattern of header bits and pushes the rewritten word into an external stream, or tests a masked header field against a fixed reference value and reports the match on the result port without touching the stream.

The operands and the command word are valid only in the cycle that `start` is high. They are captured on that qualified clock edge, and every result is ready one qualified edge later. Every clock edge with `clk_en` low is ignored. The outbound stream is valid/ready. `out_valid` stays high for exactly one qualified cycle per written word, or longer across edges that are not qualified. A transfer happens on a qualified edge where both `out_valid` and `out_ready` are high. The unit does not wait for back-pressure. If `out_ready` is low on the qualified edge that retires a word, that word is lost and the sticky `ovf_flag` is raised. Only reset clears `ovf_flag`.

Top module: `hdr_mask_unit`

## Requirements
- R1: While `rst` is high, and after it, `result` is 0, `out_valid` is 0, `out_data` is 0 and `ovf_flag` is 0.
- R2: With command bits [1:0] = 00 (pass), the word {dataa, datab} is placed on `out_data` and `result` equals `dataa`, one qualified edge after the start edge.
- R3: The header mask is built from the command word. Bit [2] picks the header field: 0 means word bits 47:32 and 1 means word bits 63:48. Bit 3+i of the command word covers bits 2i+1:2i of that field, for i from 0 to 7. All other mask bits are 0.
- R4: With bits [1:0] = 01 (clear), the masked bits of the word are forced to 0 and the rest are unchanged. The result goes to `out_data`, and its upper half goes to `result`.
- R5: With bits [1:0] = 10 (set), the masked bits are forced to 1 and the rest are unchanged. The result goes to `out_data`, and its upper half goes to `result`.
- R6: With bits [1:0] = 11 (compare), `result` is 1 when (dataa AND mask) equals (HDR_REF AND mask), and 0 otherwise. `datab` has no effect, and `out_valid` is low on the following cycle.
- R7: After a writing command, `out_valid` is high for one qualified cycle and then falls. A writing command issued while `out_valid` is high keeps it high with the new word.
- R8: A qualified edge that sees `out_valid` high and `out_ready` low sets `ovf_flag`. The flag then stays set until reset.
- R9: An edge with `clk_en` low changes no output and starts nothing, even with `start` high.
- R10: Operand and command values outside the start cycle do not affect `result` or `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| clk_en | input | 1 | Clock qualifier; edges with it low are ignored |
| start | input | 1 | Instruction issue strobe |
| dataa | input | 32 | Operand, upper half of the packet word |
| datab | input | 32 | Operand, lower half of the packet word |
| prefix | input | 11 | Command word: operation, field select, bit pattern |
| result | output | 32 | Rewritten header half or compare status |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 64 | Stream word |
| ovf_flag | output | 1 | Sticky flag for a word dropped under back-pressure |

## Verification
`result`, `out_valid` and `out_data` are due on the first qualified edge after the start edge. The fall of `out_valid` and any setting of `ovf_flag` are due one qualified edge after that. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands in the half cycle right after the edge that should produce it. Operands are scrambled after every start, and `clk_en` is dropped between edges. These confirm that values outside the sample cycle and unqualified edges leave those outputs untouched.

// File: rtl/hmu_pkg.sv
package hmu_pkg;
  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_CLR  = 2'b01,
    OP_SET  = 2'b10,
    OP_CMP  = 2'b11
  } hmu_op_e;
endpackage

// File: rtl/hmu_mask_gen.sv
module hmu_mask_gen #(
  parameter int HALF_W  = 32,
  parameter int FIELD_W = 16,
  parameter int PAT_W   = 8,
  localparam int NUM_FIELDS = HALF_W / FIELD_W,
  localparam int SEL_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int LANE = FIELD_W / PAT_W
) (
  input  logic [SEL_W-1:0]  field_sel,
  input  logic [PAT_W-1:0]  pattern,
  output logic [HALF_W-1:0] hdr_mask
);
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    for (genvar p = 0; p < PAT_W; p++) begin : g_lane
      assign hdr_mask[f*FIELD_W + p*LANE +: LANE] =
        {LANE{pattern[p] && (field_sel == SEL_W'(f))}};
    end
  end
endmodule

// File: rtl/hmu_bitop.sv
module hmu_bitop
  import hmu_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter logic [HALF_W-1:0] REF_WORD = '0,
  localparam int WORD_W = 2 * HALF_W
) (
  input  hmu_op_e           op,
  input  logic [WORD_W-1:0] word_in,
  input  logic [HALF_W-1:0] hdr_mask,
  output logic [WORD_W-1:0] word_out,
  output logic [HALF_W-1:0] res_val,
  output logic              writes
);
  logic [WORD_W-1:0] full_mask;
  logic              hit;

  assign full_mask = {hdr_mask, {HALF_W{1'b0}}};
  assign hit = ((word_in[WORD_W-1:HALF_W] & hdr_mask) == (REF_WORD & hdr_mask));

  always_comb begin
    word_out = word_in;
    writes   = 1'b1;
    unique case (op)
      OP_PASS: word_out = word_in;
      OP_CLR:  word_out = word_in & ~full_mask;
      OP_SET:  word_out = word_in | full_mask;
      OP_CMP:  writes = 1'b0;
      default: word_out = word_in;
    endcase
    res_val = (op == OP_CMP) ? HALF_W'(hit) : word_out[WORD_W-1:HALF_W];
  end
endmodule

// File: rtl/hmu_stream_port.sv
module hmu_stream_port #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              ovf_flag
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      ovf_flag  <= 1'b0;
    end else if (clk_en) begin
      out_valid <= load;
      if (load) out_data <= load_word;
      if (out_valid && !out_ready) ovf_flag <= 1'b1;
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag); // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (clk_en && out_valid && !out_ready) |=> ovf_flag); // R8
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> ($stable(out_data) && $stable(out_valid))); // R9
endmodule

// File: rtl/hdr_mask_unit.sv
module hdr_mask_unit
  import hmu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 16,
  parameter int PAT_W   = 8,
  parameter logic [DATA_W-1:0] HDR_REF = 32'hABCD_1234,
  localparam int NUM_FIELDS = DATA_W / FIELD_W,
  localparam int SEL_W = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int PFX_W = 2 + SEL_W + PAT_W,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              start,
  input  logic [DATA_W-1:0] dataa,
  input  logic [DATA_W-1:0] datab,
  input  logic [PFX_W-1:0]  prefix,
  output logic [DATA_W-1:0] result,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              ovf_flag
);
  hmu_op_e           op;
  logic [DATA_W-1:0] hdr_mask;
  logic [WORD_W-1:0] new_word;
  logic [DATA_W-1:0] res_val;
  logic              writes;
  logic              fire;

  assign op   = hmu_op_e'(prefix[1:0]);
  assign fire = clk_en && start;

  hmu_mask_gen #(.HALF_W(DATA_W), .FIELD_W(FIELD_W), .PAT_W(PAT_W)) u_mask (
    .field_sel (prefix[2 +: SEL_W]),
    .pattern   (prefix[2+SEL_W +: PAT_W]),
    .hdr_mask  (hdr_mask)
  );

  hmu_bitop #(.HALF_W(DATA_W), .REF_WORD(HDR_REF)) u_op (
    .op       (op),
    .word_in  ({dataa, datab}),
    .hdr_mask (hdr_mask),
    .word_out (new_word),
    .res_val  (res_val),
    .writes   (writes)
  );

  hmu_stream_port #(.WORD_W(WORD_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .clk_en    (clk_en),
    .load      (fire && writes),
    .load_word (new_word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .ovf_flag  (ovf_flag)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       result <= '0;
    else if (fire) result <= res_val;
  end

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (fire && prefix[1:0] == 2'b11) |=> !out_valid); // R6
  AST_WRITE_VALID: assert property (@(posedge clk) disable iff (rst)
    (fire && prefix[1:0] != 2'b11) |=> out_valid); // R7
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !start && out_valid) |=> !out_valid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(result)); // R9
endmodule

// File: tb/sim_hdr_mask_unit.sv
module sim_hdr_mask_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_en = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dataa = '0;
  logic [31:0] datab = '0;
  logic [10:0] prefix = '0;
  logic [31:0] result;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        ovf_flag;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_mask_unit u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .start(start),
    .dataa(dataa), .datab(datab), .prefix(prefix), .result(result),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic [10:0] pfx;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        vld;
    logic [63:0] data;
  } vec_t;

  // pass, clear, set, compare vectors (reference word ABCD1234)
  localparam vec_t VECS [8] = '{
    '{11'h000, 32'hDEADBEEF, 32'h01234567, 32'hDEADBEEF, 1'b1, 64'hDEADBEEF_01234567}, // R2
    '{11'h7F9, 32'hDEADBEEF, 32'h01234567, 32'hDEAD0000, 1'b1, 64'hDEAD0000_01234567}, // R4 field0 full
    '{11'h07E, 32'h12345678, 32'hAAAA5555, 32'h12FF5678, 1'b1, 64'h12FF5678_AAAA5555}, // R5 R3 field1 low byte
    '{11'h40D, 32'hFFFFFFFF, 32'h00000000, 32'h3FFCFFFF, 1'b1, 64'h3FFCFFFF_00000000}, // R4 R3 lanes 0 and 7
    '{11'h7FF, 32'hABCD9999, 32'h11111111, 32'h00000001, 1'b0, 64'h0},                 // R6 match
    '{11'h07B, 32'h00000035, 32'h22222222, 32'h00000000, 1'b0, 64'h0},                 // R6 mismatch
    '{11'h07B, 32'hFFFFFF34, 32'hFFFFFFFF, 32'h00000001, 1'b0, 64'h0},                 // R6 masked match
    '{11'h002, 32'h0F0F0F0F, 32'h5A5A5A5A, 32'h0F0F0F0F, 1'b1, 64'h0F0F0F0F_5A5A5A5A}  // R5 empty mask
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one instruction; returns at the falling edge after the start edge
  task automatic issue(input logic [10:0] p, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    clk_en = 1'b1; start = 1'b1; prefix = p; dataa = a; datab = b;
    @(negedge clk);
    start = 1'b0; prefix = ~p; dataa = ~a; datab = ~b;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result", 64'(result), 64'h0);
    check("R1 valid", 64'(out_valid), 64'h0);
    check("R1 ovf", 64'(ovf_flag), 64'h0);
    rst = 1'b0;

    foreach (VECS[i]) begin
      issue(VECS[i].pfx, VECS[i].a, VECS[i].b);
      check($sformatf("R2-6 vec%0d result", i), 64'(result), 64'(VECS[i].res));
      check($sformatf("R7 vec%0d valid", i), 64'(out_valid), 64'(VECS[i].vld));
      if (VECS[i].vld) check($sformatf("R2-5 vec%0d data", i), out_data, VECS[i].data);
      @(negedge clk);
      check($sformatf("R7 vec%0d valid drop", i), 64'(out_valid), 64'h0);
      check($sformatf("R10 vec%0d result hold", i), 64'(result), 64'(VECS[i].res));
    end
    check("R8 ovf clear with ready", 64'(ovf_flag), 64'h0);

    // R9: start with clk_en low does nothing
    @(negedge clk);
    clk_en = 1'b0; start = 1'b1; prefix = 11'h000; dataa = 32'h55555555; datab = 32'h66666666;
    @(negedge clk);
    start = 1'b0;
    check("R9 result held", 64'(result), 64'h0F0F0F0F);
    check("R9 no write", 64'(out_valid), 64'h0);

    // R9: pending word held across unqualified edges
    issue(11'h000, 32'h13572468, 32'h24681357);
    clk_en = 1'b0;
    @(negedge clk);
    check("R9 valid held", 64'(out_valid), 64'h1);
    check("R9 data held", out_data, 64'h13572468_24681357);
    clk_en = 1'b1;
    @(negedge clk);
    check("R7 valid drop after enable", 64'(out_valid), 64'h0);

    // R7: back-to-back writes
    @(negedge clk);
    clk_en = 1'b1; start = 1'b1; prefix = 11'h000; dataa = 32'h11112222; datab = 32'h33334444;
    @(negedge clk);
    prefix = 11'h000; dataa = 32'h55556666; datab = 32'h77778888;
    check("R7 first word", out_data, 64'h11112222_33334444);
    @(negedge clk);
    start = 1'b0; dataa = '0; datab = '0;
    check("R7 second valid", 64'(out_valid), 64'h1);
    check("R7 second word", out_data, 64'h55556666_77778888);
    @(negedge clk);
    check("R7 drop after pair", 64'(out_valid), 64'h0);

    // R8: back-pressure drop sets sticky flag
    out_ready = 1'b0;
    issue(11'h000, 32'hCAFEF00D, 32'h0BADBEEF);
    check("R8 not yet set", 64'(ovf_flag), 64'h0);
    @(negedge clk);
    out_ready = 1'b1;
    check("R8 set on drop", 64'(ovf_flag), 64'h1);
    issue(11'h000, 32'h1, 32'h2);
    @(negedge clk);
    check("R8 sticky", 64'(ovf_flag), 64'h1);

    // R1: reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset result", 64'(result), 64'h0);
    check("R1 reset ovf", 64'(ovf_flag), 64'h0);
    check("R1 reset data", out_data, 64'h0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule